// File: doc/BRIEF.md
# Smart Card Contact Power-Down Sequencer

This block takes a live smart card contact interface down to the unpowered state in a fixed order. There are two ways to start the shutdown. The first is a card event, such as removal or a supply fault. It arrives asynchronously and passes through a synchronizer. The second is a firmware write that sets the supply-select field to zero.

Once the shutdown starts, the block does four things in order, with a programmable gap in card clock cycles before each one:

1. It pulls card reset low.
2. It gates the card clock off.
3. It forces the data line low.
4. It drops the supply enable.

A firmware-started shutdown may first hold the contacts live for a programmable number of elementary time units (ETUs), counted on a one-cycle tick. A card event never waits, and it cuts short any pending ETU wait.

After a synchronous reset the contacts are unpowered. A firmware write of a non-zero supply-select value hands the block a live interface: the activation itself is done by other logic. After the last step, the block pulses a done flag and returns to the unpowered idle state.

Top module: `card_deact_seq`

## Requirements
- R1: While `rst` is high, and on the first clock edge at which it is high, the outputs go to the unpowered pattern: `card_rst_o`=0, `card_clk_en_o`=0, `io_force_low_o`=1, `vcc_en_o`=0, `done_o`=0. The block is then in unpowered idle.
- R2: In unpowered idle, a write (`sel_wr_i`=1) with a non-zero `sel_wdata_i` puts the contacts live from the next edge: `card_rst_o`=1, `card_clk_en_o`=1, `io_force_low_o`=0, `vcc_en_o`=1. A non-zero write while the contacts are live changes nothing.
- R3: While live, `card_event_i` high starts the shutdown with no ETU wait. The event is seen two clock edges after it is first sampled, because of the two-stage synchronizer. If the synchronized event and a zero write arrive on the same edge, the event path wins.
- R4: While live, a write of `sel_wdata_i`=0 starts the shutdown. If `vcc_off_etu_i`=N is greater than 0, the block first waits for N cycles with `etu_tick_i` high, and the shutdown starts on the edge that samples the N-th tick. If N=0, it starts on the edge that samples the write.
- R5: Let S be the edge at which the shutdown starts. `card_rst_o` falls `gap_rst_i` edges after S. `card_clk_en_o` falls `gap_clk_i` edges later. `io_force_low_o` rises `gap_io_i` edges after that. `vcc_en_o` falls `gap_vcc_i` edges after that. A gap value of 0 acts as 1.
- R6: The order is fixed on every cycle. Reset high implies the clock is enabled. The clock enabled implies the data line is not forced low. The data line not forced low implies supply on.
- R7: A card event during a pending ETU wait ends the wait, and the four steps start at once.
- R8: `done_o` is high for exactly one cycle, on the edge where `vcc_en_o` falls, and the block is then idle again. Card events and supply-select writes of any value made after the shutdown starts have no effect on the outputs. A zero write in unpowered idle also has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Card clock domain clock |
| rst | input | 1 | Synchronous active-high reset |
| card_event_i | input | 1 | Asynchronous card event level (removal, fault) |
| sel_wr_i | input | 1 | Supply-select write strobe |
| sel_wdata_i | input | SEL_W | Supply-select value written; zero requests shutdown |
| gap_rst_i | input | GAP_W | Cycles from shutdown start to reset low |
| gap_clk_i | input | GAP_W | Cycles from reset low to clock stop |
| gap_io_i | input | GAP_W | Cycles from clock stop to data line low |
| gap_vcc_i | input | GAP_W | Cycles from data line low to supply off |
| vcc_off_etu_i | input | ETU_W | ETU wait before a firmware-started shutdown |
| etu_tick_i | input | 1 | One-cycle pulse per elementary time unit |
| card_rst_o | output | 1 | Card reset line level |
| card_clk_en_o | output | 1 | Card clock enable |
| io_force_low_o | output | 1 | Forces the card data line low |
| vcc_en_o | output | 1 | Card supply enable |
| done_o | output | 1 | One-cycle pulse when the supply is removed |

## Verification
Some properties are checked by assertions on every cycle:

- the three pairwise ordering relations between reset, clock, data line and supply;
- done lasting a single cycle and coinciding with supply removal;
- the supply falling only together with done, and rising only after a non-zero write;
- each clock stop being preceded by reset already low for at least one cycle.

Other behaviour can only be shown by the bench's scenarios against its cycle model:

- the exact gap lengths, including a zero gap and the 255 maximum;
- the ETU count, and its abort by a card event;
- the event winning when it arrives on the same edge as a zero write;
- triggers being ignored while a shutdown runs;
- a reset taken in the middle of a shutdown.

// File: rtl/cds_pkg.sv
package cds_pkg;

  typedef enum logic [2:0] {
    CDS_OFF,
    CDS_LIVE,
    CDS_ETU,
    CDS_T1,
    CDS_T2,
    CDS_T3,
    CDS_T4
  } cds_state_e;

  function automatic logic is_step(input cds_state_e s);
    return (s == CDS_T1) || (s == CDS_T2) || (s == CDS_T3) || (s == CDS_T4);
  endfunction

endpackage

// File: rtl/cds_sync.sv
module cds_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_i,
  output logic sync_o
);

  logic [STAGES-1:0] shreg;

  always_ff @(posedge clk) begin
    if (rst) shreg <= '0;
    else     shreg <= {shreg[STAGES-2:0], async_i};
  end

  assign sync_o = shreg[STAGES-1];

endmodule

// File: rtl/cds_downcnt.sv
module cds_downcnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  input  logic         dec_i,
  output logic         last_o
);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                         cnt <= '0;
    else if (load_i)                 cnt <= val_i;
    else if (dec_i && cnt != '0)     cnt <= cnt - 1'b1;
  end

  // a count of 0 or 1 means the current cycle/tick is the final one
  assign last_o = (cnt[W-1:1] == '0);

endmodule

// File: rtl/card_deact_seq.sv
module card_deact_seq
  import cds_pkg::*;
#(
  parameter int GAP_W       = 8,
  parameter int ETU_W       = 8,
  parameter int SEL_W       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             card_event_i,
  input  logic             sel_wr_i,
  input  logic [SEL_W-1:0] sel_wdata_i,
  input  logic [GAP_W-1:0] gap_rst_i,
  input  logic [GAP_W-1:0] gap_clk_i,
  input  logic [GAP_W-1:0] gap_io_i,
  input  logic [GAP_W-1:0] gap_vcc_i,
  input  logic [ETU_W-1:0] vcc_off_etu_i,
  input  logic             etu_tick_i,
  output logic             card_rst_o,
  output logic             card_clk_en_o,
  output logic             io_force_low_o,
  output logic             vcc_en_o,
  output logic             done_o
);

  cds_state_e       state, nxt;
  logic             evt_sync;
  logic             fw_off, fw_on;
  logic             step_load, step_last;
  logic [GAP_W-1:0] step_val;
  logic             etu_load, etu_dec, etu_last;

  cds_sync #(.STAGES(SYNC_STAGES)) u_evt_sync (
    .clk     (clk),
    .rst     (rst),
    .async_i (card_event_i),
    .sync_o  (evt_sync)
  );

  cds_downcnt #(.W(GAP_W)) u_step_cnt (
    .clk    (clk),
    .rst    (rst),
    .load_i (step_load),
    .val_i  (step_val),
    .dec_i  (is_step(state)),
    .last_o (step_last)
  );

  cds_downcnt #(.W(ETU_W)) u_etu_cnt (
    .clk    (clk),
    .rst    (rst),
    .load_i (etu_load),
    .val_i  (vcc_off_etu_i),
    .dec_i  (etu_dec),
    .last_o (etu_last)
  );

  assign fw_off  = sel_wr_i && (sel_wdata_i == '0);
  assign fw_on   = sel_wr_i && (sel_wdata_i != '0);
  assign etu_dec = (state == CDS_ETU) && etu_tick_i;

  always_comb begin
    nxt      = state;
    etu_load = 1'b0;
    unique case (state)
      CDS_OFF:  if (fw_on) nxt = CDS_LIVE;
      CDS_LIVE: begin
        if (evt_sync) nxt = CDS_T1;
        else if (fw_off) begin
          if (vcc_off_etu_i == '0) nxt = CDS_T1;
          else begin
            nxt      = CDS_ETU;
            etu_load = 1'b1;
          end
        end
      end
      CDS_ETU:  if (evt_sync || (etu_tick_i && etu_last)) nxt = CDS_T1;
      CDS_T1:   if (step_last) nxt = CDS_T2;
      CDS_T2:   if (step_last) nxt = CDS_T3;
      CDS_T3:   if (step_last) nxt = CDS_T4;
      CDS_T4:   if (step_last) nxt = CDS_OFF;
      default:  nxt = CDS_OFF;
    endcase
  end

  // gap for the step being entered
  always_comb begin
    step_load = (nxt != state) && is_step(nxt);
    unique case (nxt)
      CDS_T1:  step_val = gap_rst_i;
      CDS_T2:  step_val = gap_clk_i;
      CDS_T3:  step_val = gap_io_i;
      CDS_T4:  step_val = gap_vcc_i;
      default: step_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state          <= CDS_OFF;
      card_rst_o     <= 1'b0;
      card_clk_en_o  <= 1'b0;
      io_force_low_o <= 1'b1;
      vcc_en_o       <= 1'b0;
      done_o         <= 1'b0;
    end else begin
      state          <= nxt;
      card_rst_o     <= (nxt == CDS_LIVE) || (nxt == CDS_ETU) || (nxt == CDS_T1);
      card_clk_en_o  <= (nxt == CDS_LIVE) || (nxt == CDS_ETU) || (nxt == CDS_T1)
                        || (nxt == CDS_T2);
      io_force_low_o <= !((nxt == CDS_LIVE) || (nxt == CDS_ETU) || (nxt == CDS_T1)
                        || (nxt == CDS_T2) || (nxt == CDS_T3));
      vcc_en_o       <= (nxt != CDS_OFF);
      done_o         <= (state == CDS_T4) && (nxt == CDS_OFF);
    end
  end

endmodule

// File: rtl/cds_chk.sv
module cds_chk #(
  parameter int SEL_W = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             sel_wr_i,
  input logic [SEL_W-1:0] sel_wdata_i,
  input logic             card_rst_o,
  input logic             card_clk_en_o,
  input logic             io_force_low_o,
  input logic             vcc_en_o,
  input logic             done_o
);

  logic rst_q = 1'b0;
  always_ff @(posedge clk) rst_q <= rst;

  // R1: unpowered pattern one edge into reset
  always @(negedge clk) begin
    if (rst_q === 1'b1 && rst === 1'b1)
      a_r1_reset_state: assert (!card_rst_o && !card_clk_en_o && io_force_low_o
                                && !vcc_en_o && !done_o);
  end

  a_r6_rst_needs_clk: assert property (@(posedge clk) disable iff (rst)
    card_rst_o |-> card_clk_en_o);
  a_r6_clk_needs_io: assert property (@(posedge clk) disable iff (rst)
    card_clk_en_o |-> !io_force_low_o);
  a_r6_io_needs_vcc: assert property (@(posedge clk) disable iff (rst)
    !io_force_low_o |-> vcc_en_o);
  a_r5_clk_after_rst: assert property (@(posedge clk) disable iff (rst)
    $fell(card_clk_en_o) |-> (!card_rst_o && !$past(card_rst_o)));
  a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  a_r8_done_with_vcc_off: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (!vcc_en_o && $past(vcc_en_o)));
  a_r8_vcc_falls_with_done: assert property (@(posedge clk) disable iff (rst)
    $fell(vcc_en_o) |-> done_o);
  a_r2_vcc_rises_on_write: assert property (@(posedge clk) disable iff (rst)
    $rose(vcc_en_o) |-> ($past(sel_wr_i) && $past(sel_wdata_i) != '0));

endmodule

bind card_deact_seq cds_chk #(.SEL_W(SEL_W)) u_cds_chk (
  .clk            (clk),
  .rst            (rst),
  .sel_wr_i       (sel_wr_i),
  .sel_wdata_i    (sel_wdata_i),
  .card_rst_o     (card_rst_o),
  .card_clk_en_o  (card_clk_en_o),
  .io_force_low_o (io_force_low_o),
  .vcc_en_o       (vcc_en_o),
  .done_o         (done_o)
);

// File: tb/test_card_deact_seq.sv
`timescale 1ns/1ps
module test_card_deact_seq;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       card_event = 1'b0;
  logic       sel_wr = 1'b0;
  logic [1:0] sel_wdata = 2'b00;
  logic [7:0] g_rst = 8'd1, g_clk = 8'd1, g_io = 8'd1, g_vcc = 8'd1;
  logic [7:0] etu_n = 8'd0;
  logic       etu_tick = 1'b0;
  logic       o_rst, o_clk, o_io, o_vcc, o_done;

  always #2.5 clk = ~clk;

  card_deact_seq i_card_deact_seq (
    .clk(clk), .rst(rst), .card_event_i(card_event),
    .sel_wr_i(sel_wr), .sel_wdata_i(sel_wdata),
    .gap_rst_i(g_rst), .gap_clk_i(g_clk), .gap_io_i(g_io), .gap_vcc_i(g_vcc),
    .vcc_off_etu_i(etu_n), .etu_tick_i(etu_tick),
    .card_rst_o(o_rst), .card_clk_en_o(o_clk), .io_force_low_o(o_io),
    .vcc_en_o(o_vcc), .done_o(o_done)
  );

  int    checks = 0, fails = 0, done_cnt = 0, wd = 0;
  string cur_req = "R1";

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  localparam int PH_OFF = 0, PH_LIVE = 1, PH_WAIT = 2, PH_SEQ = 3;
  int   cyc = 0, ph = PH_OFF, left = 0;
  int   d_rst, d_clk, d_io, d_vcc;
  bit   ev_q[$];
  bit   ev_now;
  logic e_rst = 0, e_clk = 0, e_io = 1, e_vcc = 0, e_done = 0;
  bit   m_valid = 0;

  function automatic int gap(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  task automatic begin_down(input int c);
    d_rst = c + gap(g_rst);
    d_clk = d_rst + gap(g_clk);
    d_io  = d_clk + gap(g_io);
    d_vcc = d_io + gap(g_vcc);
    ph    = PH_SEQ;
  endtask

  always @(posedge clk) begin
    cyc = cyc + 1;
    m_valid = 1;
    if (rst) begin
      ph = PH_OFF;
      ev_q = {1'b0, 1'b0};
      e_rst = 0; e_clk = 0; e_io = 1; e_vcc = 0; e_done = 0;
    end else begin
      ev_q.push_back(card_event);
      ev_now = ev_q.pop_front();
      e_done = 0;
      if (ph == PH_OFF) begin
        if (sel_wr && sel_wdata != 0) begin
          ph = PH_LIVE; e_rst = 1; e_clk = 1; e_io = 0; e_vcc = 1;
        end
      end else if (ph == PH_LIVE) begin
        if (ev_now) begin_down(cyc);
        else if (sel_wr && sel_wdata == 0) begin
          if (etu_n == 0) begin_down(cyc);
          else begin ph = PH_WAIT; left = etu_n; end
        end
      end else if (ph == PH_WAIT) begin
        if (ev_now) begin_down(cyc);
        else if (etu_tick) begin
          if (left <= 1) begin_down(cyc);
          else left = left - 1;
        end
      end else begin
        if (cyc == d_rst) e_rst = 0;
        if (cyc == d_clk) e_clk = 0;
        if (cyc == d_io)  e_io = 1;
        if (cyc == d_vcc) begin e_vcc = 0; e_done = 1; ph = PH_OFF; end
      end
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (o_done) done_cnt++;
    if (m_valid) begin
      chk(cur_req, {o_rst, o_clk, o_io, o_vcc, o_done},
                   {e_rst, e_clk, e_io, e_vcc, e_done});
      chk("R6", (o_rst && !o_clk) || (o_clk && o_io) || (!o_io && !o_vcc), 0);
    end
  end

  // ETU tick source
  bit tick_en = 0;
  int tick_ph = 0;
  always @(negedge clk) begin
    tick_ph++;
    etu_tick <= tick_en && (tick_ph % 7 == 0);
  end

  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      fails++;
      $display("FAIL R8 watchdog actual=%0d expected<%0d", wd, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic wr(input logic [1:0] v);
    @(negedge clk); sel_wr = 1; sel_wdata = v;
    @(negedge clk); sel_wr = 0;
  endtask

  task automatic set_gaps(input int a, input int b, input int c, input int d);
    g_rst = 8'(a); g_clk = 8'(b); g_io = 8'(c); g_vcc = 8'(d);
  endtask

  initial begin
    int k, d0;
    repeat (3) @(negedge clk);
    chk("R1", {o_rst, o_clk, o_io, o_vcc, o_done}, 5'b00100);
    rst = 0;

    // R2: arm, then non-zero write ignored
    cur_req = "R2";
    wr(2'b01); @(negedge clk);
    chk("R2", {o_rst, o_clk, o_io, o_vcc}, 4'b1101);
    wr(2'b10); repeat (3) @(negedge clk);
    chk("R2", {o_rst, o_clk, o_io, o_vcc}, 4'b1101);

    // R3/R5: card event, gaps 3,5,2,4
    cur_req = "R5"; set_gaps(3, 5, 2, 4); d0 = done_cnt;
    @(negedge clk); card_event = 1;
    k = 0; while (o_rst && k < 100) begin @(negedge clk); k++; end
    chk("R5 rst delay", k, 2 + 3 + 1);
    k = 0; while (o_clk && k < 100) begin @(negedge clk); k++; end
    chk("R5 clk gap", k, 5);
    repeat (15) @(negedge clk); card_event = 0;
    chk("R8 done count", done_cnt - d0, 1);
    chk("R3 vcc off", o_vcc, 0);

    // R4: firmware shutdown with ETU wait
    cur_req = "R4"; set_gaps(1, 1, 1, 1); etu_n = 3; tick_en = 1;
    wr(2'b01); wr(2'b00); repeat (3) @(negedge clk);
    chk("R4 still waiting", o_rst, 1);
    repeat (40) @(negedge clk);
    chk("R4 vcc off", o_vcc, 0);
    tick_en = 0;

    // R5 boundary: gaps 0,255,0,2, no ETU wait
    cur_req = "R5"; set_gaps(0, 255, 0, 2); etu_n = 0;
    wr(2'b01); wr(2'b00); @(negedge clk);
    chk("R5 zero gap", o_rst, 0);
    repeat (200) @(negedge clk);
    chk("R5 clk held 255", o_clk, 1);
    repeat (70) @(negedge clk);
    chk("R5 vcc off", o_vcc, 0);

    // R7: event aborts ETU wait
    cur_req = "R7"; set_gaps(2, 2, 2, 2); etu_n = 5;
    wr(2'b01); wr(2'b00); repeat (10) @(negedge clk);
    chk("R7 waiting", o_rst, 1);
    card_event = 1; repeat (20) @(negedge clk); card_event = 0;
    chk("R7 vcc off", o_vcc, 0);

    // R3 priority: event and zero write on one edge
    cur_req = "R3"; etu_n = 4;
    wr(2'b01); @(negedge clk);
    card_event = 1; @(negedge clk); @(negedge clk);
    sel_wr = 1; sel_wdata = 2'b00; @(negedge clk); sel_wr = 0;
    repeat (3) @(negedge clk);
    chk("R3 event wins", o_rst, 0);
    card_event = 0; repeat (15) @(negedge clk);

    // R8: triggers ignored during shutdown and in idle
    cur_req = "R8"; set_gaps(4, 4, 4, 4); etu_n = 0; d0 = done_cnt;
    wr(2'b01); wr(2'b00); repeat (2) @(negedge clk);
    wr(2'b00); wr(2'b11);
    card_event = 1; @(negedge clk); card_event = 0;
    repeat (20) @(negedge clk);
    chk("R8 done count", done_cnt - d0, 1);
    chk("R8 not re-armed", o_vcc, 0);
    wr(2'b00); repeat (3) @(negedge clk);
    chk("R8 idle write", {o_vcc, o_done}, 2'b00);

    // R1: reset mid-shutdown
    cur_req = "R1"; set_gaps(10, 10, 10, 10);
    wr(2'b01); wr(2'b00); repeat (12) @(negedge clk);
    rst = 1; repeat (2) @(negedge clk);
    chk("R1 mid reset", {o_rst, o_clk, o_io, o_vcc, o_done}, 5'b00100);
    rst = 0; repeat (3) @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule